// File: doc/BRIEF.md
# Current-Mode PWM Output Latch

This block is the digital pulse former at the heart of a peak-current-mode switching regulator controller. Once per oscillator period it raises the gate-drive request for the power switch, then lets the current-sense comparator end that pulse as soon as the inductor current reaches its programmed peak. Once a pulse has been ended it cannot restart before the next period begins, so at most one pulse occurs per period. The oscillator phase and the comparator trip flag reach the block as synchronous digital levels. All analog parts of the loop lie outside it: the comparator, the timing network, the error amplifier and the output driver.

A strap input selects one of two rate variants. In full-rate mode a pulse starts with every charge phase of the oscillator, and the discharge phase blanks the output, so the discharge time sets the dead time. In half-rate mode a toggle stage lets only every other oscillator period carry a pulse. Inside an enabled period the discharge blank is not applied, so the pulse can last one whole oscillator period, and the duty ceiling is exactly one half. A supervisor enable holds the output low whenever supply or reference is not good. The same enable also re-arms the toggle, so the first pulse after start-up is known in advance.

Top module: `cm_pwm_latch`

## Requirements
- R1: While `rst_n` is low the output `gate_drive` is low at every clock edge. A period start is recognised only on a low-to-high change of `osc_charge` that is seen after reset, so `osc_charge` already high at reset release does not raise the output.
- R2: `osc_charge` is 1 in the charge phase and 0 in the discharge phase. A period start is the first clock edge that samples `osc_charge` at 1 after it was sampled at 0. When enabled and allowed by the rate mode, `gate_drive` is high from that edge on.
- R3: `half_rate` at 0 selects full-rate mode. In that mode every period start raises the output, and every edge that samples `osc_charge` at 0 forces `gate_drive` low.
- R4: An edge that samples `cs_trip` at 1 while `gate_drive` is high drives `gate_drive` low. The output then stays low until the next period start, even if `cs_trip` falls again or keeps toggling.
- R5: A `cs_trip` already high at a period start does not stop the output from rising at that edge. The pulse then ends at the following edge.
- R6: `cs_trip` seen while `gate_drive` is low has no effect on the output.
- R7: `half_rate` at 1 selects half-rate mode. Pulses start only on alternate period starts. The discharge phase does not end a pulse. A pulse started at one period start is forced low at the next one, so with a free-running oscillator the output is high for exactly half of all cycles.
- R8: An edge that samples `run_enable` at 0 drives `gate_drive` low. Period starts seen while `run_enable` is 0 raise no pulse.
- R9: While `run_enable` is 0 (or in full-rate mode) the half-rate toggle returns to its pulse-enabled phase. The first period start in half-rate mode after that therefore raises a pulse.
- R10: If `osc_charge` stays at 1 without end, a trip still ends the running pulse, and the output then stays low for as long as no new period start arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_charge | input | 1 | Oscillator phase: 1 = charge, 0 = discharge |
| cs_trip | input | 1 | Current-sense comparator trip, synchronous |
| run_enable | input | 1 | Supervisor enable (supply and reference good) |
| half_rate | input | 1 | Rate strap: 0 = full rate, 1 = half rate with 50% clamp |
| gate_drive | output | 1 | Gate-drive request to the power switch |

## Verification
Every result of this block lands in one register, and there are no extra pipeline stages. A period start, a trip, a discharge blank, a lost enable or a reset therefore shows on `gate_drive` at the same clock edge that first samples the causing input level. The bench changes inputs on the falling edge and samples the output shortly after the next rising edge, so each check lines up with that single edge. Its duty checks count high cycles over whole periods of a free-running phase pattern. A run of cycles with the oscillator held in charge shows that the latched-low state persists.

// File: rtl/cm_pwm_pkg.sv
// Package: shared definitions for the current-mode PWM output latch.
// Assumes: the rate strap is a static level decoded as a single bit.
package cm_pwm_pkg;

    // Rate variant selected by the strap input.
    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;

    // Reset value of the remembered oscillator phase: charge, so that a
    // phase already high at reset release is not taken as a period start.
    localparam logic PHASE_RESET = 1'b1;

    // Reset value of the half-rate toggle: the pulse-enabled phase.
    localparam logic ARM_RESET = 1'b1;

    // Decode the strap into the rate variant.
    function automatic rate_e decode_rate(input logic strap);
        return strap ? RATE_HALF : RATE_FULL;
    endfunction

endpackage

// File: rtl/cm_pwm_phase_track.sv
// Module: tracks the oscillator phase and marks period starts.
// Assumes: osc_charge is already synchronous to clk (1 = charge phase).
module cm_pwm_phase_track
    import cm_pwm_pkg::*;
#(
    parameter logic RESET_PHASE = PHASE_RESET
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_charge,
    output logic period_start,
    output logic in_discharge
);

    logic phase_q;

    // Remember the phase sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= RESET_PHASE;
        end else begin
            phase_q <= osc_charge;
        end
    end

    // A start is the first charge sample after a discharge sample.
    always_comb begin
        period_start = osc_charge && !phase_q;
        in_discharge = !osc_charge;
    end

endmodule

// File: rtl/cm_pwm_rate_toggle.sv
// Module: half-rate toggle that permits a pulse on alternate periods.
// Assumes: re-arms to the pulse-enabled phase while disabled or in full
// rate, so the first half-rate period after start-up always pulses.
module cm_pwm_rate_toggle
    import cm_pwm_pkg::*;
#(
    parameter logic ARM_INIT = ARM_RESET
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_enable,
    input  rate_e rate,
    input  logic  period_start,
    output logic  pulse_permit
);

    logic arm_q;

    // Flip the toggle on each half-rate period start; re-arm otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_INIT;
        end else if (!run_enable || rate == RATE_FULL) begin
            arm_q <= ARM_INIT;
        end else if (period_start) begin
            arm_q <= !arm_q;
        end
    end

    // Full rate permits every period; half rate only armed periods.
    always_comb begin
        pulse_permit = (rate == RATE_FULL) ? 1'b1 : arm_q;
    end

endmodule

// File: rtl/cm_pwm_pulse_latch.sv
// Module: the output latch that forms one gate pulse per period.
// Assumes: priority is kill, then period start, then blank, then trip;
// a trip counts only while the output is already high.
module cm_pwm_pulse_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic period_start,
    input  logic pulse_permit,
    input  logic blank,
    input  logic trip,
    output logic gate
);

    logic gate_q;

    // Set at a permitted start, clear on kill, blank or trip, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (kill) begin
            gate_q <= 1'b0;
        end else if (period_start) begin
            gate_q <= pulse_permit;
        end else if (blank) begin
            gate_q <= 1'b0;
        end else if (gate_q && trip) begin
            gate_q <= 1'b0;
        end
    end

    assign gate = gate_q;

endmodule

// File: rtl/cm_pwm_latch.sv
// Module: top of the current-mode PWM output latch.
// Assumes: all inputs are synchronous to clk; the strap is static while
// pulses are running.
module cm_pwm_latch
    import cm_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_charge,
    input  logic cs_trip,
    input  logic run_enable,
    input  logic half_rate,
    output logic gate_drive
);

    rate_e rate;
    logic  period_start;
    logic  in_discharge;
    logic  pulse_permit;
    logic  blank;

    // Decode the strap and gate the discharge blank by the rate mode.
    always_comb begin
        rate  = decode_rate(half_rate);
        blank = in_discharge && (rate == RATE_FULL);
    end

    cm_pwm_phase_track u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_charge   (osc_charge),
        .period_start (period_start),
        .in_discharge (in_discharge)
    );

    cm_pwm_rate_toggle u_toggle (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_enable   (run_enable),
        .rate         (rate),
        .period_start (period_start),
        .pulse_permit (pulse_permit)
    );

    cm_pwm_pulse_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .kill         (!run_enable),
        .period_start (period_start),
        .pulse_permit (pulse_permit),
        .blank        (blank),
        .trip         (cs_trip),
        .gate         (gate_drive)
    );

endmodule

// File: rtl/cm_pwm_latch_chk.sv
// Module: property checker for cm_pwm_latch, attached by bind.
// Assumes: sees only the top-level ports.
module cm_pwm_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_charge,
    input logic cs_trip,
    input logic run_enable,
    input logic half_rate,
    input logic gate_drive
);

    // R1: reset forces the output low.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !gate_drive);

    // R2: the output rises only from an enabled period start.
    p_rise_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_drive) |-> ($past(osc_charge) && !$past(osc_charge, 2) && $past(run_enable)));

    // R3: full-rate discharge blanks the output.
    p_discharge_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_charge && !half_rate) |=> !gate_drive);

    // R4: a trip during a pulse ends it.
    p_trip_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_drive && cs_trip) |=> !gate_drive);

    // R6: a low output stays low until a period start.
    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_drive && !(osc_charge && !$past(osc_charge))) |=> !gate_drive);

    // R7: in half rate, a pulse running at a period start is ended.
    p_half_period_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && $past(half_rate) && gate_drive && osc_charge && !$past(osc_charge)) |=> !gate_drive);

    // R8: a lost enable forces the output low.
    p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_enable |=> !gate_drive);

endmodule

bind cm_pwm_latch cm_pwm_latch_chk i_cm_pwm_latch_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_charge (osc_charge),
    .cs_trip    (cs_trip),
    .run_enable (run_enable),
    .half_rate  (half_rate),
    .gate_drive (gate_drive)
);

// File: tb/test_cm_pwm_latch.sv
// Bench: table-driven stimulus followed by directed duty, stop and reset tests.
module test_cm_pwm_latch;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_charge = 1'b1;
    logic cs_trip = 1'b0;
    logic run_enable = 1'b0;
    logic half_rate = 1'b0;
    logic gate_drive;

    int checks = 0;
    int failures = 0;

    always #2 clk = !clk;

    cm_pwm_latch i_cm_pwm_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_charge (osc_charge),
        .cs_trip    (cs_trip),
        .run_enable (run_enable),
        .half_rate  (half_rate),
        .gate_drive (gate_drive)
    );

    typedef struct packed {
        logic       osc;
        logic       trip;
        logic       en;
        logic       half;
        logic       exp_gate;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 42;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1},  // R1 no start at release
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},  // R3
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd2},  // R2 start
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 blank
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd2},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 trip
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 latched
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 trip while low
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd5},  // R5 trip at start
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 switch to half
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},  // R7 no blank
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 skipped period
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd4},  // R4 in half rate
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 enable lost
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd9},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd9},  // R9 re-armed
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 start while off
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 trip, osc stopped
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10}
    };

    // Compare the output with the expected level and log a failure.
    task automatic check(input logic exp, input int req, input string what);
        checks++;
        if (gate_drive !== exp) begin
            failures++;
            $display("FAIL R%0d %s: gate_drive=%b expected=%b", req, what, gate_drive, exp);
        end
    endtask

    // Drive one set of inputs, then sample just after the next rising edge.
    task automatic step(input logic osc, input logic trip, input logic en, input logic half);
        @(negedge clk);
        osc_charge = osc;
        cs_trip    = trip;
        run_enable = en;
        half_rate  = half;
        @(posedge clk);
        #1;
    endtask

    // Free-run the oscillator (5 charge, 3 discharge) and count high cycles.
    task automatic free_run(input logic half, input int periods, output int highs);
        highs = 0;
        for (int p = 0; p < periods; p++) begin
            for (int c = 0; c < 8; c++) begin
                step((c < 5), 1'b0, 1'b1, half);
                if (gate_drive === 1'b1) highs++;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int highs;
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1, "output during reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].osc, VEC[i].trip, VEC[i].en, VEC[i].half);
            check(VEC[i].exp_gate, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R10: oscillator stays in charge; output must stay low.
        for (int k = 0; k < 50; k++) begin
            step(1'b1, k[0], 1'b1, 1'b0);
            if (k % 10 == 9) check(1'b0, 10, "held low with oscillator stopped");
        end

        // R3: full-rate duty, 5 of 8 cycles per period.
        step(1'b0, 1'b0, 1'b1, 1'b0);
        free_run(1'b0, 4, highs);
        checks++;
        if (highs != 20) begin
            failures++;
            $display("FAIL R3 full-rate duty: highs=%0d expected=%0d", highs, 20);
        end

        // R7: half-rate duty, exactly half of all cycles.
        step(1'b0, 1'b0, 1'b1, 1'b1);
        free_run(1'b1, 4, highs);
        checks++;
        if (highs != 16) begin
            failures++;
            $display("FAIL R7 half-rate duty: highs=%0d expected=%0d", highs, 16);
        end

        // R1: reset during a pulse, then release with the phase already high.
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check(1'b1, 2, "pulse before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(1'b0, 1, "reset clears pulse");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check(1'b0, 1, "no start at release with phase high");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule